// File: doc/BRIEF.md
# Single-Answer Window Watchdog

This block supervises software with a two-part time window. Each watchdog cycle opens with a closed window of fixed length. An open window of fixed length follows it. Software is expected to write one answer byte during the open window. The block compares that byte with an expected byte supplied from outside. It also checks when the byte arrived. A failure counter goes down after a good cycle and up after a bad one. Four status flags describe how the last cycle ended.

A write during the closed window counts as premature. That cycle ends as soon as the closed window runs out. In every other case the cycle runs to the end of the open window, even when a good answer arrived early in that window. A one-clock pulse marks each cycle end, and the flags and counter change at that moment.

Software reads the status with a read strobe. The strobe clears the flags, and they stay clear until the next cycle end. The expected byte is produced elsewhere. Whatever is done with the failure count is also handled outside this block.

Top module: `wwd_single`

## Requirements
- R1: Reset clears all four flags and the failure count to 0, holds `cycle_end` low, and starts a new closed window. A cycle that sees no write then ends CLOSE_TICKS+OPEN_TICKS clocks after reset is released.
- R2: A write in the closed window sets `flag_early` and adds one to the failure count. The cycle ends when the closed window ends, CLOSE_TICKS clocks after the cycle began.
- R3: A closed-window write whose byte differs from `exp_data` also sets `flag_ans_err`. When every closed-window byte matches, `flag_ans_err` stays 0.
- R4: A first open-window write that matches `exp_data` leaves all flags 0 and subtracts one from the failure count. The cycle still ends CLOSE_TICKS+OPEN_TICKS clocks after it began.
- R5: A first open-window write that does not match sets `flag_ans_err` only and adds one to the failure count. The cycle runs to the end of the open window.
- R6: A second or later write in the same open window counts as incorrect. It sets `flag_ans_err` and adds one to the failure count, even if every byte matched.
- R7: A cycle with no write in either window sets `flag_timeout` only. It adds one to the failure count at the end of the open window.
- R8: `flag_seq_err` is always 0.
- R9: At each cycle end the flags are replaced by that cycle's result. Between cycle ends they hold their value unless a read clears them. `cycle_end` is high for exactly the one clock after the last tick of a cycle.
- R10: When `stat_rd` is high at a clock edge, the flags are 0 after that edge. The exception is an edge that is also a cycle end: there the new cycle's flags take effect.
- R11: The failure count stops at FAIL_MAX and does not grow further. It stops at 0 and does not fall further.
- R12: A write on the last clock of the closed window counts as premature (R2). A write on the last clock of the open window counts as an open-window answer (R4/R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ans_we | input | 1 | Answer write strobe, one answer per high clock |
| ans_data | input | 8 | Answer byte |
| exp_data | input | 8 | Expected answer byte |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| flag_ans_err | output | 1 | Last cycle had a wrong or surplus answer |
| flag_early | output | 1 | Last cycle had an answer in the closed window |
| flag_seq_err | output | 1 | Sequence error flag, always 0 |
| flag_timeout | output | 1 | Last cycle had no answer at all |
| fail_cnt | output | $clog2(FAIL_MAX+1) | Saturating failure counter |
| cycle_end | output | 1 | One-clock pulse at each cycle end |

## Verification
The assertions assume that `stat_rd` is low in the clock right after reset is released. They also assume both window lengths are at least one clock. Under those assumptions, a cycle end always follows the previous one by either the closed-window length or the full cycle length. The stimulus changes inputs only on falling edges. It keeps `stat_rd` and `ans_we` low except for single-clock pulses placed at chosen cycle offsets, so every write falls in a known window tick.

// File: rtl/wwd_single.sv
`timescale 1ns/1ps
module wwd_single #(
  parameter int CLOSE_TICKS = 16,
  parameter int OPEN_TICKS  = 32,
  parameter int FAIL_MAX    = 7,
  localparam int FAIL_W = $clog2(FAIL_MAX + 1),
  localparam int TMAX   = (CLOSE_TICKS > OPEN_TICKS) ? CLOSE_TICKS : OPEN_TICKS,
  localparam int TW     = (TMAX > 1) ? $clog2(TMAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ans_we,
  input  logic [7:0]        ans_data,
  input  logic [7:0]        exp_data,
  input  logic              stat_rd,
  output logic              flag_ans_err,
  output logic              flag_early,
  output logic              flag_seq_err,
  output logic              flag_timeout,
  output logic [FAIL_W-1:0] fail_cnt,
  output logic              cycle_end
);

  localparam logic [TW-1:0]     C_LAST = TW'(CLOSE_TICKS - 1);
  localparam logic [TW-1:0]     O_LAST = TW'(OPEN_TICKS - 1);
  localparam logic [FAIL_W-1:0] F_TOP  = FAIL_W'(FAIL_MAX);

  logic          in_open_q;
  logic [TW-1:0] tick_q;
  logic          early_q, cerr_q, oans_q, obad_q;

  logic mism, in_closed, win_last;
  logic early_n, cerr_n, oans_n, obad_n;
  logic end_now, good_cycle;
  logic nx_err, nx_early, nx_to;

  assign mism      = (ans_data != exp_data);
  assign in_closed = !in_open_q;
  assign win_last  = in_closed ? (tick_q == C_LAST) : (tick_q == O_LAST);

  assign early_n = early_q | (in_closed & ans_we);
  assign cerr_n  = cerr_q  | (in_closed & ans_we & mism);
  assign oans_n  = oans_q  | (in_open_q & ans_we);
  assign obad_n  = obad_q  | (in_open_q & ans_we & (mism | oans_q));

  assign end_now    = win_last & (in_open_q | early_n);
  assign good_cycle = in_open_q & oans_n & !obad_n;

  assign nx_early = in_closed;
  assign nx_err   = in_closed ? cerr_n : obad_n;
  assign nx_to    = in_open_q & !oans_n;

  assign flag_seq_err = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_open_q <= 1'b0;
      tick_q    <= '0;
      early_q   <= 1'b0;
      cerr_q    <= 1'b0;
      oans_q    <= 1'b0;
      obad_q    <= 1'b0;
    end else if (win_last) begin
      in_open_q <= in_closed & !early_n;
      tick_q    <= '0;
      early_q   <= 1'b0;
      cerr_q    <= 1'b0;
      oans_q    <= 1'b0;
      obad_q    <= 1'b0;
    end else begin
      tick_q  <= tick_q + 1'b1;
      early_q <= early_n;
      cerr_q  <= cerr_n;
      oans_q  <= oans_n;
      obad_q  <= obad_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_ans_err <= 1'b0;
      flag_early   <= 1'b0;
      flag_timeout <= 1'b0;
      cycle_end    <= 1'b0;
    end else begin
      cycle_end <= end_now;
      if (end_now) begin
        flag_ans_err <= nx_err;
        flag_early   <= nx_early;
        flag_timeout <= nx_to;
      end else if (stat_rd) begin
        flag_ans_err <= 1'b0;
        flag_early   <= 1'b0;
        flag_timeout <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_cnt <= '0;
    end else if (end_now) begin
      if (good_cycle) begin
        if (fail_cnt != '0) fail_cnt <= fail_cnt - 1'b1;
      end else if (fail_cnt != F_TOP) begin
        fail_cnt <= fail_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wwd_single_chk.sv
`timescale 1ns/1ps
module wwd_single_chk #(
  parameter int CLOSE_TICKS = 16,
  parameter int OPEN_TICKS  = 32,
  parameter int FAIL_MAX    = 7,
  localparam int FAIL_W = $clog2(FAIL_MAX + 1),
  localparam int GW     = $clog2(CLOSE_TICKS + OPEN_TICKS + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ans_we,
  input logic [7:0]        ans_data,
  input logic [7:0]        exp_data,
  input logic              stat_rd,
  input logic              flag_ans_err,
  input logic              flag_early,
  input logic              flag_seq_err,
  input logic              flag_timeout,
  input logic [FAIL_W-1:0] fail_cnt,
  input logic              cycle_end
);

  localparam logic [GW-1:0] G_SHORT = GW'(CLOSE_TICKS);
  localparam logic [GW-1:0] G_FULL  = GW'(CLOSE_TICKS + OPEN_TICKS);
  localparam logic [GW-1:0] G_TOP   = {GW{1'b1}};
  localparam logic [FAIL_W-1:0] F_TOP = FAIL_W'(FAIL_MAX);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         gap_q <= '0;
    else if (cycle_end) gap_q <= GW'(1);
    else if (gap_q != G_TOP) gap_q <= gap_q + 1'b1;
  end

  AST_LEN_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && flag_early) |-> (gap_q == G_SHORT)); // R2
  AST_LEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !flag_early) |-> (gap_q == G_FULL)); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_end && !$past(stat_rd)) |-> $stable({flag_ans_err, flag_early, flag_timeout})); // R9
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |-> $stable(fail_cnt)); // R9
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd) && !cycle_end) |-> !(flag_ans_err || flag_early || flag_timeout)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fail_cnt <= F_TOP); // R11
  AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_timeout |-> !(flag_early || flag_ans_err)); // R7
  AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !cycle_end); // R9

endmodule

bind wwd_single wwd_single_chk #(
  .CLOSE_TICKS(CLOSE_TICKS),
  .OPEN_TICKS(OPEN_TICKS),
  .FAIL_MAX(FAIL_MAX)
) chk_i (.*);

// File: tb/wwd_single_tb_top.sv
`timescale 1ns/1ps
module wwd_single_tb_top;
  localparam int C  = 6;
  localparam int O  = 10;
  localparam int FM = 7;
  localparam logic [7:0] EXP = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ans_we = 1'b0;
  logic [7:0] ans_data = 8'h00;
  logic [7:0] exp_data = EXP;
  logic       stat_rd = 1'b0;
  logic       flag_ans_err, flag_early, flag_seq_err, flag_timeout, cycle_end;
  logic [2:0] fail_cnt;

  always #2.5 clk = ~clk;

  wwd_single #(.CLOSE_TICKS(C), .OPEN_TICKS(O), .FAIL_MAX(FM)) dut_i (
    .clk(clk), .rst_n(rst_n), .ans_we(ans_we), .ans_data(ans_data),
    .exp_data(exp_data), .stat_rd(stat_rd), .flag_ans_err(flag_ans_err),
    .flag_early(flag_early), .flag_seq_err(flag_seq_err),
    .flag_timeout(flag_timeout), .fail_cnt(fail_cnt), .cycle_end(cycle_end)
  );

  int errs = 0;
  int checks = 0;
  int exp_fail = 0;
  int mid_flags, after_flags;
  bit done = 1'b0;

  // flag code: ans_err=8, early=4, seq_err=2, timeout=1
  function automatic int fl();
    return {28'd0, flag_ans_err, flag_early, flag_seq_err, flag_timeout};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic fail_up();
    if (exp_fail < FM) exp_fail++;
  endtask

  task automatic fail_dn();
    if (exp_fail > 0) exp_fail--;
  endtask

  task automatic run_cycle(input int w1, input logic [7:0] d1, input int w2,
                           input logic [7:0] d2, input int rd, output int len);
    int i;
    i = 0;
    mid_flags = -1;
    after_flags = -1;
    while (1) begin
      ans_we   = (i == w1) || (i == w2);
      ans_data = (i == w2) ? d2 : d1;
      stat_rd  = (i == rd);
      if (i == rd) mid_flags = fl();
      @(negedge clk);
      i++;
      if (i == rd + 1) after_flags = fl();
      if (cycle_end || i > 4 * (C + O)) break;
    end
    ans_we = 1'b0;
    stat_rd = 1'b0;
    len = i;
  endtask

  task automatic end_check(input string req, input int len, input int exp_len, input int exp_fl);
    chk(req, "cycle length", len, exp_len);
    chk(req, "flags", fl(), exp_fl);
    chk(req, "fail count", int'(fail_cnt), exp_fail);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "flags in reset", fl(), 0);
    chk("R1", "fail count in reset", int'(fail_cnt), 0);
    chk("R1", "cycle_end in reset", int'(cycle_end), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_timeout(input string req);
    int len;
    run_cycle(-1, EXP, -1, EXP, -1, len);
    fail_up();
    end_check(req, len, C + O, 1);
  endtask

  task automatic t_ontime(input int at, input string req);
    int len;
    run_cycle(at, EXP, -1, EXP, -1, len);
    fail_dn();
    end_check(req, len, C + O, 0);
  endtask

  task automatic t_early(input int at, input logic [7:0] d, input string req);
    int len;
    run_cycle(at, d, -1, EXP, -1, len);
    fail_up();
    end_check(req, len, C, (d == EXP) ? 4 : 12);
  endtask

  task automatic t_open_bad();
    int len;
    run_cycle(C + 1, ~EXP, -1, EXP, -1, len);
    fail_up();
    end_check("R5", len, C + O, 8);
  endtask

  task automatic t_double();
    int len;
    run_cycle(C + 1, EXP, C + 4, EXP, -1, len);
    fail_up();
    end_check("R6", len, C + O, 8);
  endtask

  task automatic t_read();
    int len;
    t_timeout("R7");
    run_cycle(C + 2, EXP, -1, EXP, 2, len);
    chk("R9", "flags held before read", mid_flags, 1);
    chk("R10", "flags after read", after_flags, 0);
    fail_dn();
    end_check("R4", len, C + O, 0);
  endtask

  task automatic t_seq();
    int len;
    run_cycle(C + 3, 8'h00, C + 5, EXP, -1, len);
    fail_up();
    chk("R8", "seq_err flag", int'(flag_seq_err), 0);
    chk("R6", "fail count", int'(fail_cnt), exp_fail);
  endtask

  task automatic t_sat();
    for (int k = 0; k < FM + 2; k++) t_timeout("R11");
    chk("R11", "count held at top", int'(fail_cnt), FM);
    for (int k = 0; k < FM + 2; k++) t_ontime(C + 1, "R11");
    chk("R11", "count held at zero", int'(fail_cnt), 0);
  endtask

  initial begin
    t_reset();
    t_timeout("R1");
    t_ontime(C + 3, "R4");
    t_early(2, EXP, "R2");
    t_early(1, ~EXP, "R3");
    t_open_bad();
    t_double();
    t_early(C - 1, EXP, "R12");
    t_ontime(C + O - 1, "R12");
    t_read();
    t_seq();
    t_sat();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule